// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

A two-dimensional grid of one-bit processing elements. One micro-instruction is broadcast to every element, and all elements execute it in the same clock cycle. Each element holds a private bit-addressable local memory, a primary bit register, a carry flip-flop, a mask bit and a 32-bit shift register that streams multi-bit words. Arithmetic is done one bit per cycle. Words are processed least significant bit first, and the carry is kept between steps.

Elements trade primary-register bits with their four nearest neighbours. The array boundary can be left open with zero fill, or wrapped as a cylinder, a torus or a spiral. Every operation can be gated by a mask that comes from one of three sources: the element's mask bit, its inverse, or a bit read from local memory. A global wired-OR of all primary registers goes back to the controller so that it can branch on the result. A parallel plane input lets the controller inject one bit per element, and the plane output shows the primary registers.

Top module: `simd_bit_array`

## Requirements
- R1: After reset every element's primary bit, carry, mask bit and shift register are zero, so `plane_o` and `gor_o` read 0 and a carry-to-primary move (op 9) also yields a zero plane.
- R2: Plane load (op 13) copies `plane_i[i]` into element i's primary bit. Memory load (op 1) copies local bit `addr_i` into the primary bit. Memory store (op 2) writes the primary bit to local bit `addr_i`. Each element has 2^10 distinct addresses, and element i appears on `plane_o[i]`, where i = row*COLS + col.
- R3: The logic ops combine the primary bit P with local bit M at `addr_i`: op 3 gives P&M, op 4 gives P|M, op 5 gives P^M and op 6 gives ~P.
- R4: Op 7 clears the carry. Op 8 replaces P with P^M^C and sets C to the majority of P, M and C. Op 9 copies C into P. Running op 8 over bit addresses LSB first yields an N-bit sum and its carry out.
- R5: Route (op 11) loads each primary bit from the neighbour named by `dir_i`: 0 north (row-1), 1 east (col+1), 2 south (row+1), 3 west (col-1).
- R6: `topo_i` sets edge handling for the route. 0 is open and a missing neighbour gives 0. 1 is a cylinder that wraps east-west only. 2 is a torus that wraps both ways. 3 is a spiral: east and west follow the row-major index i±1 modulo the element count, and north and south wrap.
- R7: Shift (op 12) moves shift register bit 0 into P and shifts the register right by one, with the old P entering the top bit, so a bit pushed in reappears on P 32 shifts later.
- R8: `mmode_i` selects the enable: 0 all elements, 1 elements whose mask bit is 1, 2 elements whose mask bit is 0, 3 elements whose local bit at `addr_i` is 1. Mask load (op 10) copies local bit `addr_i` into the mask bit. A disabled element changes none of its registers or memory.
- R9: `gor_o` is 1 exactly when at least one element's primary bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Broadcast opcode (0 = no operation) |
| addr_i | input | 10 | Local memory bit address |
| dir_i | input | 2 | Route source direction |
| topo_i | input | 2 | Edge topology for routing |
| mmode_i | input | 2 | Mask mode |
| plane_i | input | ROWS*COLS | One bit per element for plane load |
| plane_o | output | ROWS*COLS | Primary bit of every element |
| gor_o | output | 1 | Wired-OR of all primary bits |

## Verification
Primary registers are visible on every cycle, so a wrong primary bit appears on `plane_o` and `gor_o` right after the edge that produced it. A corrupted carry, mask bit or shift register stays hidden until a later op reads it. The carry shows on the next carry move or in the next sum bit. A bad mask bit shows as an element that does or does not toggle under a masked invert. A bad shift-register bit returns to the plane only 32 shifts later. The serial add checks sum bits and carry against byte sums computed in the bench. Routing is checked for all sixteen combinations of topology and direction against an independent neighbour model.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDP   = 4'd1,
    OP_STP   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_NOT   = 4'd6,
    OP_CLRC  = 4'd7,
    OP_ADD   = 4'd8,
    OP_LDC   = 4'd9,
    OP_LDG   = 4'd10,
    OP_ROUTE = 4'd11,
    OP_SHFT  = 4'd12,
    OP_LDPL  = 4'd13
  } op_e;

  typedef enum logic [1:0] {
    TOPO_OPEN   = 2'd0,
    TOPO_CYL    = 2'd1,
    TOPO_TORUS  = 2'd2,
    TOPO_SPIRAL = 2'd3
  } topo_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    MSK_NONE     = 2'd0,
    MSK_DIRECT   = 2'd1,
    MSK_INVERT   = 2'd2,
    MSK_INDIRECT = 2'd3
  } mmode_e;
endpackage

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int MEM_DEPTH = 1024,
  parameter int SR_LEN    = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  op_e                          op_i,
  input  mmode_e                       mmode_i,
  input  logic [$clog2(MEM_DEPTH)-1:0] addr_i,
  input  logic                         nb_i,
  input  logic                         plane_i,
  output logic                         p_o
);
  logic                 p_q, c_q, g_q;
  logic                 p_d, c_d, g_d;
  logic [SR_LEN-1:0]    s_q, s_d;
  logic [MEM_DEPTH-1:0] mem_q;
  logic                 m_bit, en, we;

  assign m_bit = mem_q[addr_i];

  always_comb begin
    unique case (mmode_i)
      MSK_NONE:     en = 1'b1;
      MSK_DIRECT:   en = g_q;
      MSK_INVERT:   en = ~g_q;
      MSK_INDIRECT: en = m_bit;
      default:      en = 1'b1;
    endcase
  end

  always_comb begin
    p_d = p_q;
    c_d = c_q;
    g_d = g_q;
    s_d = s_q;
    we  = 1'b0;
    case (op_i)
      OP_LDP:   p_d = m_bit;
      OP_STP:   we  = 1'b1;
      OP_AND:   p_d = p_q & m_bit;
      OP_OR:    p_d = p_q | m_bit;
      OP_XOR:   p_d = p_q ^ m_bit;
      OP_NOT:   p_d = ~p_q;
      OP_CLRC:  c_d = 1'b0;
      OP_ADD: begin
        p_d = p_q ^ m_bit ^ c_q;
        c_d = (p_q & m_bit) | (c_q & (p_q ^ m_bit));
      end
      OP_LDC:   p_d = c_q;
      OP_LDG:   g_d = m_bit;
      OP_ROUTE: p_d = nb_i;
      OP_SHFT: begin
        p_d = s_q[0];
        s_d = {p_q, s_q[SR_LEN-1:1]};
      end
      OP_LDPL:  p_d = plane_i;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= 1'b0;
      c_q <= 1'b0;
      g_q <= 1'b0;
      s_q <= '0;
    end else if (en) begin
      p_q <= p_d;
      c_q <= c_d;
      g_q <= g_d;
      s_q <= s_d;
    end
  end

  // local store is not reset
  always_ff @(posedge clk_i) begin
    if (we && en) mem_q[addr_i] <= p_q;
  end

  assign p_o = p_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (p_q == $past(p_q)) && (c_q == $past(c_q)) &&
            (g_q == $past(g_q)) && (s_q == $past(s_q))); // R8

  AST_CARRY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLRC && en) |=> !c_q); // R4

  AST_SHIFT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHFT && en) |=> p_q == $past(s_q[0])); // R7
endmodule

// File: rtl/simd_route.sv
module simd_route
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic [ROWS*COLS-1:0] p_i,
  input  topo_e                topo_i,
  input  dir_e                 dir_i,
  output logic [ROWS*COLS-1:0] nb_o
);
  localparam int N = ROWS * COLS;

  logic vwrap, hwrap, spiral;
  assign vwrap  = (topo_i == TOPO_TORUS) || (topo_i == TOPO_SPIRAL);
  assign hwrap  = (topo_i == TOPO_CYL) || (topo_i == TOPO_TORUS);
  assign spiral = (topo_i == TOPO_SPIRAL);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I   = r * COLS + c;
      localparam int IN  = ((r + ROWS - 1) % ROWS) * COLS + c;
      localparam int IS  = ((r + 1) % ROWS) * COLS + c;
      localparam int IW  = r * COLS + (c + COLS - 1) % COLS;
      localparam int IE  = r * COLS + (c + 1) % COLS;
      localparam int IWS = (I + N - 1) % N;
      localparam int IES = (I + 1) % N;
      localparam bit TOP = (r == 0);
      localparam bit BOT = (r == ROWS - 1);
      localparam bit LFT = (c == 0);
      localparam bit RGT = (c == COLS - 1);

      always_comb begin
        unique case (dir_i)
          DIR_N: nb_o[I] = (!TOP || vwrap) ? p_i[IN] : 1'b0;
          DIR_S: nb_o[I] = (!BOT || vwrap) ? p_i[IS] : 1'b0;
          DIR_W: nb_o[I] = spiral ? p_i[IWS] : ((!LFT || hwrap) ? p_i[IW] : 1'b0);
          DIR_E: nb_o[I] = spiral ? p_i[IES] : ((!RGT || hwrap) ? p_i[IE] : 1'b0);
          default: nb_o[I] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/simd_gor.sv
module simd_gor #(
  parameter int N = 16
) (
  input  logic [N-1:0] bits_i,
  output logic         gor_o
);
  assign gor_o = |bits_i;
endmodule

// File: rtl/simd_bit_array.sv
module simd_bit_array
  import simd_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int MEM_DEPTH = 1024,
  parameter int SR_LEN    = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [3:0]                   op_i,
  input  logic [$clog2(MEM_DEPTH)-1:0] addr_i,
  input  logic [1:0]                   dir_i,
  input  logic [1:0]                   topo_i,
  input  logic [1:0]                   mmode_i,
  input  logic [ROWS*COLS-1:0]         plane_i,
  output logic [ROWS*COLS-1:0]         plane_o,
  output logic                         gor_o
);
  localparam int N = ROWS * COLS;

  op_e           op;
  mmode_e        mmode;
  topo_e         topo;
  dir_e          dir;
  logic [N-1:0]  p_vec, nb_vec;
  logic [ROWS-1:0] col0;

  assign op    = op_e'(op_i);
  assign mmode = mmode_e'(mmode_i);
  assign topo  = topo_e'(topo_i);
  assign dir   = dir_e'(dir_i);

  simd_route #(.ROWS(ROWS), .COLS(COLS)) u_route (
    .p_i   (p_vec),
    .topo_i(topo),
    .dir_i (dir),
    .nb_o  (nb_vec)
  );

  for (genvar i = 0; i < N; i++) begin : g_pe
    simd_pe #(.MEM_DEPTH(MEM_DEPTH), .SR_LEN(SR_LEN)) u_pe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op),
      .mmode_i(mmode),
      .addr_i (addr_i),
      .nb_i   (nb_vec[i]),
      .plane_i(plane_i[i]),
      .p_o    (p_vec[i])
    );
  end

  simd_gor #(.N(N)) u_gor (
    .bits_i(p_vec),
    .gor_o (gor_o)
  );

  assign plane_o = p_vec;

  for (genvar r = 0; r < ROWS; r++) begin : g_col0
    assign col0[r] = p_vec[r*COLS];
  end

  AST_PLANE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LDPL && mmode == MSK_NONE) |=> plane_o == $past(plane_i)); // R2

  AST_OPEN_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ROUTE && topo == TOPO_OPEN && dir == DIR_W && mmode == MSK_NONE)
    |=> col0 == '0); // R6

  AST_SPIRAL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ROUTE && topo == TOPO_SPIRAL && dir == DIR_W && mmode == MSK_NONE)
    |=> plane_o[0] == $past(plane_o[N-1])); // R6

  AST_GOR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gor_o == ($countones(plane_o) != 0)); // R9
endmodule

// File: tb/simd_bit_array_tb.sv
module simd_bit_array_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_i = '0;
  logic [9:0]   addr_i = '0;
  logic [1:0]   dir_i = '0;
  logic [1:0]   topo_i = '0;
  logic [1:0]   mmode_i = '0;
  logic [N-1:0] plane_i = '0;
  logic [N-1:0] plane_o;
  logic         gor_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  simd_bit_array #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .op_i   (op_i),
    .addr_i (addr_i),
    .dir_i  (dir_i),
    .topo_i (topo_i),
    .mmode_i(mmode_i),
    .plane_i(plane_i),
    .plane_o(plane_o),
    .gor_o  (gor_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input int addr, input logic [1:0] mm);
    @(negedge clk);
    op_i    = op;
    addr_i  = addr[9:0];
    mmode_i = mm;
    @(posedge clk);
    #1;
    op_i = 4'd0;
  endtask

  task automatic load_plane(input logic [N-1:0] pl, input logic [1:0] mm);
    plane_i = pl;
    issue(4'd13, 0, mm);
  endtask

  function automatic logic [N-1:0] ref_route(input logic [N-1:0] p, input int topo, input int dir);
    logic [N-1:0] q;
    for (int i = 0; i < N; i++) begin
      int r = i / COLS;
      int c = i % COLS;
      int rr = r;
      int cc = c;
      bit zero = 1'b0;
      case (dir)
        0: begin rr = r - 1; if (rr < 0) begin if (topo >= 2) rr = ROWS - 1; else zero = 1'b1; end end
        2: begin rr = r + 1; if (rr >= ROWS) begin if (topo >= 2) rr = 0; else zero = 1'b1; end end
        3: begin
          if (topo == 3) begin rr = ((i + N - 1) % N) / COLS; cc = ((i + N - 1) % N) % COLS; end
          else begin cc = c - 1; if (cc < 0) begin if (topo == 1 || topo == 2) cc = COLS - 1; else zero = 1'b1; end end
        end
        default: begin
          if (topo == 3) begin rr = ((i + 1) % N) / COLS; cc = ((i + 1) % N) % COLS; end
          else begin cc = c + 1; if (cc >= COLS) begin if (topo == 1 || topo == 2) cc = 0; else zero = 1'b1; end end
        end
      endcase
      q[i] = zero ? 1'b0 : p[rr*COLS+cc];
    end
    return q;
  endfunction

  task automatic t_reset;
    check("R1 plane after reset", plane_o, '0);
    check("R1 gor after reset", {15'd0, gor_o}, '0);
    issue(4'd9, 0, 2'd0);
    check("R1 carry after reset", plane_o, '0);
  endtask

  task automatic t_memory;
    logic [N-1:0] x = N'($urandom);
    load_plane(x, 2'd0);
    check("R2 plane load", plane_o, x);
    issue(4'd2, 5, 2'd0);
    load_plane(~x, 2'd0);
    issue(4'd2, 1000, 2'd0);
    issue(4'd1, 5, 2'd0);
    check("R2 load from addr 5", plane_o, x);
    issue(4'd1, 1000, 2'd0);
    check("R2 load from addr 1000", plane_o, ~x);
  endtask

  task automatic t_logic;
    logic [N-1:0] a = N'($urandom);
    logic [N-1:0] b = N'($urandom);
    load_plane(a, 2'd0); issue(4'd2, 1, 2'd0);
    load_plane(b, 2'd0); issue(4'd2, 2, 2'd0);
    issue(4'd1, 1, 2'd0); issue(4'd3, 2, 2'd0);
    check("R3 and", plane_o, a & b);
    issue(4'd1, 1, 2'd0); issue(4'd4, 2, 2'd0);
    check("R3 or", plane_o, a | b);
    issue(4'd1, 1, 2'd0); issue(4'd5, 2, 2'd0);
    check("R3 xor", plane_o, a ^ b);
    issue(4'd1, 1, 2'd0); issue(4'd6, 0, 2'd0);
    check("R3 not", plane_o, ~a);
  endtask

  task automatic t_mask;
    logic [N-1:0] g = N'($urandom);
    logic [N-1:0] x = N'($urandom);
    logic [N-1:0] y = N'($urandom);
    logic [N-1:0] z = N'($urandom);
    load_plane(g, 2'd0); issue(4'd2, 7, 2'd0); issue(4'd10, 7, 2'd0);
    load_plane(x, 2'd0);
    issue(4'd6, 0, 2'd1);
    check("R8 direct mask", plane_o, x ^ g);
    issue(4'd6, 0, 2'd2);
    check("R8 inverted mask", plane_o, ~x);
    load_plane(z, 2'd1);
    check("R8 masked plane load", plane_o, (z & g) | (~x & ~g));
    load_plane(y, 2'd0); issue(4'd2, 8, 2'd0);
    load_plane(x, 2'd0);
    issue(4'd6, 8, 2'd3);
    check("R8 indirect mask", plane_o, x ^ y);
  endtask

  task automatic add_run(input logic [7:0] a [N], input logic [7:0] b [N], input logic [N-1:0] m);
    logic [N-1:0] pl;
    logic [N-1:0] cy;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < N; i++) pl[i] = a[i][k];
      load_plane(pl, 2'd0); issue(4'd2, 16 + k, 2'd0);
      for (int i = 0; i < N; i++) pl[i] = b[i][k];
      load_plane(pl, 2'd0); issue(4'd2, 32 + k, 2'd0);
      load_plane('0, 2'd0); issue(4'd2, 48 + k, 2'd0);
    end
    load_plane(m, 2'd0); issue(4'd2, 100, 2'd0); issue(4'd10, 100, 2'd0);
    issue(4'd7, 0, 2'd0);
    for (int k = 0; k < 8; k++) begin
      issue(4'd1, 16 + k, 2'd0);
      issue(4'd8, 32 + k, 2'd1);
      issue(4'd2, 48 + k, 2'd1);
    end
    issue(4'd9, 0, 2'd0);
    for (int i = 0; i < N; i++) cy[i] = m[i] & (({1'b0, a[i]} + {1'b0, b[i]}) >= 9'd256);
    check("R4 carry out", plane_o, cy);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] s;
      issue(4'd1, 48 + k, 2'd0);
      for (int i = 0; i < N; i++) begin
        s = a[i] + b[i];
        pl[i] = m[i] & s[k];
      end
      check($sformatf("R4 sum bit %0d", k), plane_o, pl);
    end
  endtask

  task automatic t_add;
    logic [7:0] a [N];
    logic [7:0] b [N];
    for (int i = 0; i < N; i++) begin a[i] = 8'($urandom); b[i] = 8'($urandom); end
    add_run(a, b, N'($urandom));
    for (int i = 0; i < N; i++) begin a[i] = 8'hFF; b[i] = 8'(i % 2); end
    add_run(a, b, '1);
  endtask

  task automatic t_route;
    for (int t = 0; t < 4; t++) begin
      for (int d = 0; d < 4; d++) begin
        logic [N-1:0] x = N'($urandom);
        load_plane(x, 2'd0);
        topo_i = t[1:0];
        dir_i  = d[1:0];
        issue(4'd11, 0, 2'd0);
        check($sformatf("R5 R6 route topo %0d dir %0d", t, d), plane_o, ref_route(x, t, d));
      end
    end
  endtask

  task automatic t_shift;
    logic [N-1:0] xs [32];
    for (int k = 0; k < 32; k++) begin
      xs[k] = N'($urandom);
      load_plane(xs[k], 2'd0);
      issue(4'd12, 0, 2'd0);
      check("R7 shift empty", plane_o, '0);
    end
    for (int k = 0; k < 32; k++) begin
      load_plane('0, 2'd0);
      issue(4'd12, 0, 2'd0);
      check("R7 shift return", plane_o, xs[k]);
    end
  endtask

  task automatic t_gor;
    load_plane('0, 2'd0);
    check("R9 gor zero", {15'd0, gor_o}, 16'd0);
    load_plane(N'(1) << ($urandom % N), 2'd0);
    check("R9 gor single", {15'd0, gor_o}, 16'd1);
    load_plane('1, 2'd0);
    check("R9 gor all", {15'd0, gor_o}, 16'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_memory();
    t_logic();
    t_mask();
    t_add();
    t_route();
    t_shift();
    t_gor();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule